// File: doc/BRIEF.md
# Dual-Port Pin Change Interrupt Controller

This block watches two input ports of `W` pins each (port A and port B) and raises an interrupt when an enabled pin leaves its reference level. For each pin, a mode bit selects what the pin is compared against. In tracking mode the reference is the pin's own last accepted level. In default mode the reference is a fixed default bit supplied with the configuration. Before any comparison, every pin passes through a two-flop synchronizer.

When a port raises an interrupt, the block records which pins caused it in a flag vector and copies the whole port into a capture register. Both stay frozen until the interrupt is acknowledged. Software acknowledges the interrupt by reading either the capture register or the live port register. These reads reach the block as one-cycle strobes. The configuration is given as plain inputs.

Each port drives its own interrupt output. A mirror bit can combine the two outputs. A shared setting selects active-high, active-low or open-drain signalling.

Top module: `port_change_irq`

## Requirements
- R1: Each pin level appears on the live port output two clock edges after it is applied, and an interrupt flag it causes is set on the third edge.
- R2: With enable bit 1 and mode bit 0 (tracking), a pin that differs from its reference sets its flag bit when no interrupt is pending, and the capture register loads the whole synchronized port in the same cycle.
- R3: With enable bit 1 and mode bit 1 (default compare), a pin whose level differs from its default bit sets its flag. A read strobe leaves that flag set for as long as the mismatch lasts.
- R4: A default-compare flag clears only on a read strobe that arrives once the pin again equals its default bit. Returning to the default level without a read leaves the flag set.
- R5: While any flag of a port is set, later pin changes on that port alter neither its flags nor its capture register.
- R6: A strobe on either the capture read or the port read of a port clears every tracking-mode flag of that port on the next edge.
- R7: On a clearing read, the tracking reference loads the pins' current levels. Pins held at those levels raise nothing new, and a later return to the old levels raises a new interrupt.
- R8: A pin with enable bit 0 never sets its flag. Clearing the enable bit of a flagged pin drops that flag on the next edge.
- R9: With the mirror input at 0, each output reflects only its own port. With it at 1, both outputs assert when either port has a flag set.
- R10: With open-drain 0, the output enable is 1 and the level is the active state when active-high is 1, or its inverse when active-high is 0.
- R11: With open-drain 1, the level is 0, the output enable equals the active state, and the active-high input has no effect.
- R12: After reset, all flags and captures are 0 and both outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_a_i | input | W | Port A pad levels (asynchronous) |
| pin_b_i | input | W | Port B pad levels (asynchronous) |
| en_a_i | input | W | Port A per-pin interrupt enable |
| en_b_i | input | W | Port B per-pin interrupt enable |
| mode_a_i | input | W | Port A compare mode, 1 = default compare, 0 = tracking |
| mode_b_i | input | W | Port B compare mode |
| dflt_a_i | input | W | Port A default levels |
| dflt_b_i | input | W | Port B default levels |
| rd_cap_a_i | input | 1 | Capture register A read strobe |
| rd_port_a_i | input | 1 | Port register A read strobe |
| rd_cap_b_i | input | 1 | Capture register B read strobe |
| rd_port_b_i | input | 1 | Port register B read strobe |
| mirror_i | input | 1 | Combine both interrupt sources onto both outputs |
| active_high_i | input | 1 | Push-pull polarity, 1 = active high |
| open_drain_i | input | 1 | Open-drain signalling select |
| port_a_o | output | W | Synchronized port A levels |
| port_b_o | output | W | Synchronized port B levels |
| cap_a_o | output | W | Port A capture register |
| cap_b_o | output | W | Port B capture register |
| flag_a_o | output | W | Port A per-pin interrupt flags |
| flag_b_o | output | W | Port B per-pin interrupt flags |
| irq_a_o | output | 1 | Interrupt A level |
| irq_a_oe_o | output | 1 | Interrupt A output enable |
| irq_b_o | output | 1 | Interrupt B level |
| irq_b_oe_o | output | 1 | Interrupt B output enable |

## Verification
Every pin of both ports is stepped through a single-pin change in both compare modes. A second pin is then changed while the first is pending, and the first read arrives during the mismatch. These stimuli separate tracking clears from default-compare persistence and show that the capture holds the first snapshot, not a later one.

Restoring the pins after a tracking-mode clear shows that the reference was reloaded at the read and was not left at its old value. Disabled pins and enables dropped while a flag is pending are tried on their own. Finally, all four pending combinations of the two ports are crossed with every mirror, polarity and open-drain setting, which covers each output case.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

    typedef enum logic [1:0] {
        SIG_ACT_LOW    = 2'd0,
        SIG_ACT_HIGH   = 2'd1,
        SIG_OPEN_DRAIN = 2'd2
    } sig_mode_e;

    function automatic sig_mode_e pick_sig_mode(input logic od, input logic ah);
        if (od) begin
            return SIG_OPEN_DRAIN;
        end
        return ah ? SIG_ACT_HIGH : SIG_ACT_LOW;
    endfunction

endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

    // cycles since reset, used only to bound the latency check
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_sync_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/pcirq_port.sv
module pcirq_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] dflt,
    input  logic         rd,
    output logic [W-1:0] flag,
    output logic [W-1:0] cap,
    output logic         pend
);
    typedef struct packed {
        logic [W-1:0] refv;
        logic [W-1:0] flag;
        logic [W-1:0] cap;
    } port_t;

    port_t st_d, st_q;

    logic [W-1:0] miss_ref;
    logic [W-1:0] miss_def;
    logic [W-1:0] cond;
    logic [W-1:0] keep;
    logic         pend_w;

    always_comb begin
        miss_ref = pin_s ^ st_q.refv;
        miss_def = pin_s ^ dflt;
        cond     = en & ((mode & miss_def) | (~mode & miss_ref));
        keep     = en & mode & miss_def;
        pend_w   = |st_q.flag;

        st_d = st_q;
        if (!pend_w) begin
            st_d.refv = pin_s;
            if (|cond) begin
                st_d.flag = cond;
                st_d.cap  = pin_s;
            end
        end else if (rd) begin
            st_d.flag = st_q.flag & keep;
            st_d.refv = pin_s;
        end
        st_d.flag = st_d.flag & en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign cap  = st_q.cap;
    assign pend = pend_w;

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_w && (|cond)) |=> ((flag == $past(cond)) && (cap == $past(pin_s))));

    p_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && rd) |=> ((flag & $past(keep & flag & en)) == $past(keep & flag & en)));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && !rd) |=> ($stable(cap) && ((flag & ~$past(flag)) == '0)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && rd) |=> ((flag & ~$past(keep)) == '0));

    p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(en)) == '0));

endmodule

// File: rtl/pcirq_out.sv
module pcirq_out
    import pcirq_pkg::*;
(
    input  logic      pend_a,
    input  logic      pend_b,
    input  logic      mirror,
    input  sig_mode_e sig_mode,
    output logic      lvl_a,
    output logic      oe_a,
    output logic      lvl_b,
    output logic      oe_b
);
    logic [1:0] act;
    logic [1:0] lvl;
    logic [1:0] oe;

    always_comb begin
        act[0] = pend_a | (mirror & pend_b);
        act[1] = pend_b | (mirror & pend_a);
    end

    for (genvar g = 0; g < 2; g++) begin : g_drv
        always_comb begin
            unique case (sig_mode)
                SIG_OPEN_DRAIN: begin
                    lvl[g] = 1'b0;
                    oe[g]  = act[g];
                end
                SIG_ACT_HIGH: begin
                    lvl[g] = act[g];
                    oe[g]  = 1'b1;
                end
                default: begin
                    lvl[g] = ~act[g];
                    oe[g]  = 1'b1;
                end
            endcase
        end
    end

    assign lvl_a = lvl[0];
    assign oe_a  = oe[0];
    assign lvl_b = lvl[1];
    assign oe_b  = oe[1];

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import pcirq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_a_i,
    input  logic [W-1:0] pin_b_i,
    input  logic [W-1:0] en_a_i,
    input  logic [W-1:0] en_b_i,
    input  logic [W-1:0] mode_a_i,
    input  logic [W-1:0] mode_b_i,
    input  logic [W-1:0] dflt_a_i,
    input  logic [W-1:0] dflt_b_i,
    input  logic         rd_cap_a_i,
    input  logic         rd_port_a_i,
    input  logic         rd_cap_b_i,
    input  logic         rd_port_b_i,
    input  logic         mirror_i,
    input  logic         active_high_i,
    input  logic         open_drain_i,
    output logic [W-1:0] port_a_o,
    output logic [W-1:0] port_b_o,
    output logic [W-1:0] cap_a_o,
    output logic [W-1:0] cap_b_o,
    output logic [W-1:0] flag_a_o,
    output logic [W-1:0] flag_b_o,
    output logic         irq_a_o,
    output logic         irq_a_oe_o,
    output logic         irq_b_o,
    output logic         irq_b_oe_o
);
    localparam int NPORT = 2;

    logic [W-1:0] pin_v  [NPORT];
    logic [W-1:0] en_v   [NPORT];
    logic [W-1:0] mode_v [NPORT];
    logic [W-1:0] dflt_v [NPORT];
    logic         rd_v   [NPORT];
    logic [W-1:0] sync_v [NPORT];
    logic [W-1:0] flag_v [NPORT];
    logic [W-1:0] cap_v  [NPORT];
    logic         pend_v [NPORT];
    sig_mode_e    sig_mode;

    always_comb begin
        pin_v[0]  = pin_a_i;
        pin_v[1]  = pin_b_i;
        en_v[0]   = en_a_i;
        en_v[1]   = en_b_i;
        mode_v[0] = mode_a_i;
        mode_v[1] = mode_b_i;
        dflt_v[0] = dflt_a_i;
        dflt_v[1] = dflt_b_i;
        rd_v[0]   = rd_cap_a_i | rd_port_a_i;
        rd_v[1]   = rd_cap_b_i | rd_port_b_i;
        sig_mode  = pick_sig_mode(open_drain_i, active_high_i);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pcirq_sync #(.W(W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pin_v[p]),
            .dout  (sync_v[p])
        );

        pcirq_port #(.W(W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (sync_v[p]),
            .en    (en_v[p]),
            .mode  (mode_v[p]),
            .dflt  (dflt_v[p]),
            .rd    (rd_v[p]),
            .flag  (flag_v[p]),
            .cap   (cap_v[p]),
            .pend  (pend_v[p])
        );
    end

    pcirq_out u_out (
        .pend_a   (pend_v[0]),
        .pend_b   (pend_v[1]),
        .mirror   (mirror_i),
        .sig_mode (sig_mode),
        .lvl_a    (irq_a_o),
        .oe_a     (irq_a_oe_o),
        .lvl_b    (irq_b_o),
        .oe_b     (irq_b_oe_o)
    );

    assign port_a_o = sync_v[0];
    assign port_b_o = sync_v[1];
    assign cap_a_o  = cap_v[0];
    assign cap_b_o  = cap_v[1];
    assign flag_a_o = flag_v[0];
    assign flag_b_o = flag_v[1];

    p_mirror_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mirror_i && !open_drain_i && active_high_i) |->
            ((irq_a_o == (|flag_a_o)) && (irq_b_o == (|flag_b_o))));

    p_mirror_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror_i && !open_drain_i) |-> (irq_a_o == irq_b_o));

    p_push_pull_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !open_drain_i |-> (irq_a_oe_o && irq_b_oe_o));

    p_open_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        open_drain_i |-> (!irq_a_o && !irq_b_o &&
            (irq_a_oe_o == ((|flag_a_o) || (mirror_i && (|flag_b_o))))));

endmodule

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_a = '0, pin_b = '0;
    logic [W-1:0] en_a = '0, en_b = '0;
    logic [W-1:0] mode_a = '0, mode_b = '0;
    logic [W-1:0] dflt_a = '0, dflt_b = '0;
    logic         rdc_a = 1'b0, rdp_a = 1'b0, rdc_b = 1'b0, rdp_b = 1'b0;
    logic         mirror = 1'b0, ah = 1'b1, od = 1'b0;
    logic [W-1:0] port_a, port_b, cap_a, cap_b, flag_a, flag_b;
    logic         irq_a, oe_a, irq_b, oe_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    port_change_irq #(.W(W)) u_port_change_irq (
        .clk(clk), .rst_n(rst_n),
        .pin_a_i(pin_a), .pin_b_i(pin_b),
        .en_a_i(en_a), .en_b_i(en_b),
        .mode_a_i(mode_a), .mode_b_i(mode_b),
        .dflt_a_i(dflt_a), .dflt_b_i(dflt_b),
        .rd_cap_a_i(rdc_a), .rd_port_a_i(rdp_a),
        .rd_cap_b_i(rdc_b), .rd_port_b_i(rdp_b),
        .mirror_i(mirror), .active_high_i(ah), .open_drain_i(od),
        .port_a_o(port_a), .port_b_o(port_b),
        .cap_a_o(cap_a), .cap_b_o(cap_b),
        .flag_a_o(flag_a), .flag_b_o(flag_b),
        .irq_a_o(irq_a), .irq_a_oe_o(oe_a),
        .irq_b_o(irq_b), .irq_b_oe_o(oe_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input int p, input logic [W-1:0] v);
        if (p == 0) pin_a = v; else pin_b = v;
    endtask

    function automatic logic [W-1:0] flag_of(input int p);
        return (p == 0) ? flag_a : flag_b;
    endfunction

    function automatic logic [W-1:0] cap_of(input int p);
        return (p == 0) ? cap_a : cap_b;
    endfunction

    // one-cycle read strobe; returns at the negedge after the edge that saw it
    task automatic rd_pulse(input int p, input bit use_port);
        if (p == 0) begin
            if (use_port) rdp_a = 1'b1; else rdc_a = 1'b1;
        end else begin
            if (use_port) rdp_b = 1'b1; else rdc_b = 1'b1;
        end
        cyc(1);
        rdc_a = 1'b0; rdp_a = 1'b0; rdc_b = 1'b0; rdp_b = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R12 reset state
        chk("R12 flag_a", flag_a, 0);
        chk("R12 flag_b", flag_b, 0);
        chk("R12 cap_a", cap_a, 0);
        chk("R12 irq_a", {irq_a, oe_a}, 2'b01);
        chk("R12 irq_b", {irq_b, oe_b}, 2'b01);
        rst_n = 1'b1;
        cyc(2);

        // R1 synchronizer latency, all pins disabled
        pin_a = 8'h5A;
        cyc(1);
        chk("R1 port after one edge", port_a, 8'h00);
        cyc(1);
        chk("R1 port after two edges", port_a, 8'h5A);
        pin_a = '0;
        cyc(3);
        // R1 flag set on third edge
        en_a = '1;
        pin_a = 8'h02;
        cyc(2);
        chk("R1 flag not yet after two edges", flag_a, 8'h00);
        cyc(1);
        chk("R1 flag on third edge", flag_a, 8'h02);
        pin_a = '0;
        cyc(3);
        rd_pulse(0, 1'b0);
        cyc(2);
        chk("R1 clean after setup", flag_a, 8'h00);

        // per-pin sweep, both modes, both ports
        for (int m = 0; m < 2; m++) begin
            en_a = '1; en_b = '1;
            mode_a = m[0] ? '1 : '0;
            mode_b = mode_a;
            dflt_a = '0; dflt_b = '0;
            cyc(2);
            for (int p = 0; p < 2; p++) begin
                for (int i = 0; i < W; i++) begin
                    logic [W-1:0] bi, bj;
                    bi = W'(1 << i);
                    bj = W'(1 << ((i + 1) % W));
                    set_pins(p, bi);
                    cyc(4);
                    chk(m ? "R3 default flag set" : "R2 tracking flag set", flag_of(p), bi);
                    chk("R2 capture snapshot", cap_of(p), bi);
                    chk("R9 other port quiet", flag_of(1 - p), 0);
                    chk("R9 own output active", p ? irq_b : irq_a, 1'b1);
                    set_pins(p, bi | bj);
                    cyc(4);
                    chk("R5 flags frozen", flag_of(p), bi);
                    chk("R5 capture frozen", cap_of(p), bi);
                    rd_pulse(p, i[0]);
                    if (m == 0) begin
                        chk("R6 read clears tracking flag", flag_of(p), 0);
                        cyc(4);
                        chk("R7 no retrigger at reloaded level", flag_of(p), 0);
                        set_pins(p, '0);
                        cyc(4);
                        chk("R7 return to old level triggers", flag_of(p), bi | bj);
                        chk("R7 capture of return", cap_of(p), 0);
                        rd_pulse(p, 1'b0);
                        chk("R6 capture read clears", flag_of(p), 0);
                    end else begin
                        chk("R3 flag persists after read", flag_of(p), bi);
                        chk("R5 capture still frozen", cap_of(p), bi);
                        set_pins(p, '0);
                        cyc(4);
                        chk("R4 no clear without read", flag_of(p), bi);
                        rd_pulse(p, i[0]);
                        chk("R4 clear after match and read", flag_of(p), 0);
                    end
                    cyc(2);
                end
            end
        end

        // R8 enable handling, port A default compare
        mode_a = '1; dflt_a = '0; en_a = 8'hFE;
        pin_a = 8'h01;
        cyc(4);
        chk("R8 disabled pin never flags", flag_a, 0);
        chk("R8 output inactive", irq_a, 1'b0);
        en_a = 8'hFF;
        cyc(2);
        chk("R8 enabled pin flags", flag_a, 8'h01);
        en_a = 8'hFE;
        cyc(1);
        chk("R8 dropped enable clears flag", flag_a, 0);
        chk("R8 output released", irq_a, 1'b0);
        pin_a = '0; en_a = 8'hFF;
        cyc(4);

        // output sweep R9 R10 R11
        en_a = 8'h01; en_b = 8'h01;
        mode_a = '1; mode_b = '1; dflt_a = '0; dflt_b = '0;
        for (int pa = 0; pa < 2; pa++) begin
            for (int pb = 0; pb < 2; pb++) begin
                pin_a = {7'd0, pa[0]};
                pin_b = {7'd0, pb[0]};
                cyc(4);
                rdc_a = 1'b1; rdc_b = 1'b1;
                cyc(1);
                rdc_a = 1'b0; rdc_b = 1'b0;
                cyc(2);
                chk("R9 pending A setup", flag_a, {7'd0, pa[0]});
                chk("R9 pending B setup", flag_b, {7'd0, pb[0]});
                for (int c = 0; c < 8; c++) begin
                    logic act_a, act_b, ea_l, ea_o, eb_l, eb_o;
                    mirror = c[0]; ah = c[1]; od = c[2];
                    #1;
                    act_a = pa[0] | (c[0] & pb[0]);
                    act_b = pb[0] | (c[0] & pa[0]);
                    if (c[2]) begin
                        ea_l = 1'b0; ea_o = act_a;
                        eb_l = 1'b0; eb_o = act_b;
                    end else begin
                        ea_l = c[1] ? act_a : ~act_a; ea_o = 1'b1;
                        eb_l = c[1] ? act_b : ~act_b; eb_o = 1'b1;
                    end
                    chk(c[2] ? "R11 open-drain A" : "R10 push-pull A", {irq_a, oe_a}, {ea_l, ea_o});
                    chk(c[2] ? "R11 open-drain B" : "R9 R10 output B", {irq_b, oe_b}, {eb_l, eb_o});
                end
                mirror = 1'b0; ah = 1'b1; od = 1'b0;
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule